// File: doc/BRIEF.md
# Semaphore-Gated Descriptor Chain Engine

This block is one DMA channel that works through a linked list of command descriptors kept in memory. Software places descriptors in memory, points the channel at the first one through the next-address register, then adds a count to the channel's semaphore. While the count is above zero and the run gate is open, the engine reads a descriptor through a single-outstanding memory read port, runs a fixed-length data phase, and then settles the count and the chain pointer as the command word's flags direct. No single start bit exists. Work is released by the number of outstanding commands, and each command that asks for it gives one back.

Each descriptor is two consecutive 32-bit words. The first is the command word, in which bit 0 selects chaining, bit 1 selects a semaphore decrement and bit 2 selects a completion pulse. The second is the address of the next descriptor. Because a write to the semaphore adds to the count, software can extend a running or paused chain by linking new descriptors behind the last one and adding to the count.

The sequencer moves through these states. ST_IDLE goes to ST_CMD_REQ when the count is nonzero, the gate is clear and the channel is not parked. ST_CMD_REQ goes to ST_CMD_WAIT. ST_CMD_WAIT goes to ST_PTR_REQ when read data arrives. ST_PTR_REQ goes to ST_PTR_WAIT. ST_PTR_WAIT goes to ST_DATA when read data arrives. ST_DATA goes to ST_FINISH after DATA_CYCLES cycles. ST_FINISH always goes back to ST_IDLE. From any state, the gate or a channel reset forces ST_IDLE.

Top module: `cmdchain_engine`

## Requirements
- R1: The engine issues no memory request while the semaphore count is zero. Whenever the sequencer is outside idle, the count is nonzero.
- R2: Each command is fetched as two single-cycle read requests. The first is at the next-address register value and the second is at that value plus 4. Exactly DATA_CYCLES data-phase cycles then follow before the command completes. Command word bits: 0 = chain, 1 = decrement, 2 = completion pulse.
- R3: When a command completes with bit 1 set, the count decreases by one on the same clock edge.
- R4: When a command completes with bit 1 clear, the count is unchanged and processing continues while the count stays nonzero.
- R5: When a command completes with bit 0 set, the next-address register (register 0) takes the descriptor's pointer word, and fetching resumes there if the count is nonzero. With bit 0 clear, the pointer is ignored and the channel parks. A parked channel makes no request until software next writes the semaphore, even if the count is still nonzero.
- R6: A write to register 1 adds the low SEMA_W bits of the write data to the count (modulo 2^SEMA_W). Reading register 1 returns the count at any time, and it reads zero after all counted commands are done.
- R7: A semaphore write and a hardware decrement on the same edge are both applied, so the result is old + written - 1.
- R8: Register 2 bit 0 is the run gate and resets to 1. While it is 1, no request or completion pulse is issued. Setting it mid-command abandons that command with no pulse and no change to the count.
- R9: Writing 1 to bit 0 of register 3 clears the count and returns the sequencer to idle at the next edge. This works even while the channel is busy.
- R10: cmd_done is high for exactly one cycle, during the final cycle of a command, and only when that command has bit 2 set.
- R11: After reset, register 0 reads 0, register 1 reads 0, register 2 reads 1 and register 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 next address, 1 semaphore, 2 gate, 3 channel reset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Single-cycle read request |
| mem_addr | output | ADDR_W | Read address, valid with mem_req |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| cmd_done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the count boundary. A chain whose pointer still leads on must stop when the count reaches zero and resume from the loaded pointer once more count is added. A design that overwrites rather than adds, or that keeps running at zero, fetches the wrong number of descriptors. It also drives a semaphore write in the exact cycle of a decrementing completion. A design that drops either update then either skips or repeats the final descriptor. Further tests set the gate between the two descriptor reads and reset the channel during a completion cycle. A design that does not abort at once would still pulse cmd_done or decrement the count. Unchained commands with surplus count must leave the count untouched and must not fetch again.

// File: rtl/cmdchain_pkg.sv
package cmdchain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD_REQ,
        ST_CMD_WAIT,
        ST_PTR_REQ,
        ST_PTR_WAIT,
        ST_DATA,
        ST_FINISH
    } chain_state_e;

    typedef enum logic [1:0] {
        RA_NEXT  = 2'd0,
        RA_SEMA  = 2'd1,
        RA_GATE  = 2'd2,
        RA_RESET = 2'd3
    } reg_sel_e;

    localparam int CMD_BIT_CHAIN = 0;
    localparam int CMD_BIT_DEC   = 1;
    localparam int CMD_BIT_IRQ   = 2;
    localparam int CMD_FLAGS_W   = 3;

endpackage

// File: rtl/cmdchain_sema.sv
module cmdchain_sema #(
    parameter int SEMA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add_en,
    input  logic [SEMA_W-1:0] add_val,
    input  logic              dec_en,
    output logic [SEMA_W-1:0] count,
    output logic              nonzero
);

    logic [SEMA_W-1:0] count_q;
    logic [SEMA_W-1:0] inc_term;
    logic [SEMA_W-1:0] dec_term;

    always_comb begin
        inc_term = add_en ? add_val : '0;
        dec_term = dec_en ? SEMA_W'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else if (clear)
            count_q <= '0;
        else
            count_q <= count_q + inc_term - dec_term;
    end

    assign count   = count_q;
    assign nonzero = (count_q != '0);

endmodule

// File: rtl/cmdchain_fsm.sv
module cmdchain_fsm
    import cmdchain_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int DATA_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              abort,
    input  logic              go,
    input  logic              resume,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output chain_state_e      state_o,
    output logic              mem_req,
    output logic              ptr_phase,
    output logic              sema_dec,
    output logic              done_pulse,
    output logic              chain_load,
    output logic [ADDR_W-1:0] chain_ptr
);

    localparam int CNT_W = $clog2(DATA_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_CYCLES - 1);

    chain_state_e             state_q;
    chain_state_e             state_d;
    logic [CMD_FLAGS_W-1:0]   cmd_q;
    logic [ADDR_W-1:0]        ptr_q;
    logic [CNT_W-1:0]         cnt_q;
    logic                     parked_q;
    logic                     finish_fire;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (go && !parked_q) state_d = ST_CMD_REQ;
            ST_CMD_REQ:  state_d = ST_CMD_WAIT;
            ST_CMD_WAIT: if (mem_rvalid) state_d = ST_PTR_REQ;
            ST_PTR_REQ:  state_d = ST_PTR_WAIT;
            ST_PTR_WAIT: if (mem_rvalid) state_d = ST_DATA;
            ST_DATA:     if (cnt_q == CNT_LAST) state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
        if (halt || abort)
            state_d = ST_IDLE;
    end

    // Outputs
    always_comb begin
        finish_fire = (state_q == ST_FINISH) && !halt;
        mem_req     = ((state_q == ST_CMD_REQ) || (state_q == ST_PTR_REQ)) && !halt;
        ptr_phase   = (state_q == ST_PTR_REQ);
        sema_dec    = finish_fire && cmd_q[CMD_BIT_DEC];
        done_pulse  = finish_fire && cmd_q[CMD_BIT_IRQ];
        chain_load  = finish_fire && cmd_q[CMD_BIT_CHAIN];
    end

    // Descriptor capture, data-phase counter, park flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            ptr_q    <= '0;
            cnt_q    <= '0;
            parked_q <= 1'b0;
        end else begin
            if (state_q == ST_CMD_WAIT && mem_rvalid)
                cmd_q <= mem_rdata[CMD_FLAGS_W-1:0];
            if (state_q == ST_PTR_WAIT && mem_rvalid)
                ptr_q <= mem_rdata[ADDR_W-1:0];
            if (state_q == ST_DATA)
                cnt_q <= cnt_q + CNT_W'(1);
            else
                cnt_q <= '0;
            if (abort || resume)
                parked_q <= 1'b0;
            else if (finish_fire && !cmd_q[CMD_BIT_CHAIN])
                parked_q <= 1'b1;
        end
    end

    assign state_o   = state_q;
    assign chain_ptr = ptr_q;

endmodule

// File: rtl/cmdchain_engine.sv
module cmdchain_engine
    import cmdchain_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int SEMA_W      = 8,
    parameter int DATA_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              cmd_done
);

    localparam int PTR_OFS = DATA_W / 8;

    logic [ADDR_W-1:0] nxt_q;
    logic              gate_q;
    logic              wr_next;
    logic              wr_sema;
    logic              wr_gate;
    logic              soft_rst;
    logic [SEMA_W-1:0] sema_count;
    logic              sema_nz;
    logic              sema_dec;
    logic              ptr_phase;
    logic              chain_load;
    logic [ADDR_W-1:0] chain_ptr;
    chain_state_e      fsm_state;

    always_comb begin
        wr_next  = reg_we && (reg_addr == RA_NEXT);
        wr_sema  = reg_we && (reg_addr == RA_SEMA);
        wr_gate  = reg_we && (reg_addr == RA_GATE);
        soft_rst = reg_we && (reg_addr == RA_RESET) && reg_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_q  <= '0;
            gate_q <= 1'b1;
        end else begin
            if (chain_load)
                nxt_q <= chain_ptr;
            else if (wr_next)
                nxt_q <= reg_wdata[ADDR_W-1:0];
            if (wr_gate)
                gate_q <= reg_wdata[0];
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_NEXT: reg_rdata = DATA_W'(nxt_q);
            RA_SEMA: reg_rdata = DATA_W'(sema_count);
            RA_GATE: reg_rdata = DATA_W'(gate_q);
            default: reg_rdata = '0;
        endcase
    end

    assign mem_addr = nxt_q + (ptr_phase ? ADDR_W'(PTR_OFS) : '0);

    cmdchain_sema #(
        .SEMA_W (SEMA_W)
    ) u_sema (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (soft_rst),
        .add_en  (wr_sema),
        .add_val (reg_wdata[SEMA_W-1:0]),
        .dec_en  (sema_dec),
        .count   (sema_count),
        .nonzero (sema_nz)
    );

    cmdchain_fsm #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .DATA_CYCLES (DATA_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt       (gate_q),
        .abort      (soft_rst),
        .go         (sema_nz),
        .resume     (wr_sema),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .state_o    (fsm_state),
        .mem_req    (mem_req),
        .ptr_phase  (ptr_phase),
        .sema_dec   (sema_dec),
        .done_pulse (cmd_done),
        .chain_load (chain_load),
        .chain_ptr  (chain_ptr)
    );

endmodule

// File: rtl/cmdchain_engine_chk.sv
module cmdchain_engine_chk
    import cmdchain_pkg::*;
#(
    parameter int SEMA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gate_q,
    input chain_state_e      state,
    input logic [SEMA_W-1:0] sema,
    input logic              mem_req,
    input logic              cmd_done,
    input logic              sema_dec,
    input logic              reg_we,
    input logic [1:0]        reg_addr,
    input logic [SEMA_W-1:0] wdata_lo
);

    // R1: outside idle there is always outstanding count
    assert_busy_needs_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (sema != '0));

    // R3: a decrementing completion lowers the count by one
    assert_dec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH && sema_dec && !reg_we) |=> (sema == $past(sema) - SEMA_W'(1)));

    // R4: a non-decrementing completion leaves the count alone
    assert_hold_no_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH && !sema_dec && !reg_we) |=> $stable(sema));

    // R6: a semaphore write in idle adds to the count
    assert_sema_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RA_SEMA && state == ST_IDLE) |=>
        (sema == $past(sema) + $past(wdata_lo)));

    // R8: a closed gate blocks requests and pulses
    assert_gate_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q |=> (!mem_req && !cmd_done));

    // R9: channel reset clears the count and idles the sequencer
    assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RA_RESET && wdata_lo[0]) |=> (sema == '0 && state == ST_IDLE));

    // R10: completion pulse lasts a single cycle
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    // R2: each read request is a single-cycle pulse
    assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

endmodule

bind cmdchain_engine cmdchain_engine_chk #(
    .SEMA_W (SEMA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate_q   (gate_q),
    .state    (fsm_state),
    .sema     (sema_count),
    .mem_req  (mem_req),
    .cmd_done (cmd_done),
    .sema_dec (sema_dec),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .wdata_lo (reg_wdata[SEMA_W-1:0])
);

// File: tb/cmdchain_engine_bench.sv
module cmdchain_engine_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        cmd_done;

    int          n_checks = 0;
    int          n_fail = 0;
    int          done_cnt = 0;
    int          fetch_cnt = 0;
    int          mem_lat = 1;
    logic [31:0] exp_q[$];
    logic [31:0] mem [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdchain_engine u_cmdchain_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .cmd_done   (cmd_done)
    );

    // Memory responder: one outstanding read, mem_lat cycles of latency
    logic        pend;
    int          pcnt;
    logic [31:0] paddr;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0; pcnt <= 0; paddr <= '0;
            mem_rvalid <= 1'b0; mem_rdata <= '0;
        end else begin
            mem_rvalid <= 1'b0;
            if (mem_req) begin
                pend <= 1'b1; pcnt <= mem_lat; paddr <= mem_addr;
            end else if (pend) begin
                if (pcnt <= 1) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= mem[paddr[7:2]];
                    pend       <= 1'b0;
                end else begin
                    pcnt <= pcnt - 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Monitor: scoreboard of expected fetch addresses, completion counter
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req) begin
                fetch_cnt++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1", "unexpected fetch", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check(mem_addr == e, "R2", "fetch address", mem_addr, e);
                end
            end
            if (cmd_done) done_cnt++;
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic expect_desc(input logic [31:0] a);
        exp_q.push_back(a);
        exp_q.push_back(a + 32'd4);
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] flags, input logic [31:0] ptr);
        mem[a[7:2]]     = flags;
        mem[a[7:2] + 1] = ptr;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_reg(input logic [1:0] a, input logic [31:0] exp, input string req, input string what);
        logic [31:0] v;
        reg_read(a, v);
        check(v == exp, req, what, v, exp);
    endtask

    task automatic check_drained(input string req);
        check(exp_q.size() == 0, req, "pending expected fetches", exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int d0;
        int f0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        check_reg(2'd0, 32'h0, "R11", "next addr after reset");
        check_reg(2'd1, 32'h0, "R11", "sema after reset");
        check_reg(2'd2, 32'h1, "R8",  "gate after reset");
        check_reg(2'd3, 32'h0, "R11", "reg3 reads zero");

        // Gate closed: count accumulates, nothing runs
        d0 = done_cnt;
        reg_write(2'd1, 32'd2);
        idle_cycles(10);
        check_reg(2'd1, 32'd2, "R8", "sema with gate closed");
        reg_write(2'd1, 32'd3);
        check_reg(2'd1, 32'd5, "R6", "semaphore write adds");
        reg_write(2'd3, 32'd1);
        check_reg(2'd1, 32'd0, "R9", "channel reset clears count");
        check(done_cnt == d0, "R8", "no pulse while gated", done_cnt, d0);

        // Three-command chain, latency 1
        mem_lat = 1;
        put_desc(32'h40, 32'h7, 32'h60);
        put_desc(32'h60, 32'h7, 32'h80);
        put_desc(32'h80, 32'h6, 32'hA0);
        d0 = done_cnt;
        reg_write(2'd0, 32'h40);
        expect_desc(32'h40); expect_desc(32'h60); expect_desc(32'h80);
        reg_write(2'd1, 32'd3);
        reg_write(2'd2, 32'd0);
        idle_cycles(80);
        check_drained("R2");
        check(done_cnt == d0 + 3, "R10", "pulses for irq commands", done_cnt, d0 + 3);
        check_reg(2'd1, 32'd0, "R3", "count after three decrements");
        check_reg(2'd0, 32'h80, "R5", "unchained pointer not followed");

        // Non-decrementing command, latency 3
        mem_lat = 3;
        put_desc(32'h10, 32'h5, 32'h18);
        put_desc(32'h18, 32'h2, 32'h0);
        d0 = done_cnt;
        reg_write(2'd0, 32'h10);
        expect_desc(32'h10); expect_desc(32'h18);
        reg_write(2'd1, 32'd1);
        idle_cycles(80);
        check_drained("R4");
        check_reg(2'd1, 32'd0, "R4", "count after no-dec then dec");
        check(done_cnt == d0 + 1, "R10", "pulse only with irq bit", done_cnt, d0 + 1);
        check_reg(2'd0, 32'h18, "R5", "chain pointer loaded");

        // Stop at zero, resume by adding count, latency 2
        mem_lat = 2;
        put_desc(32'h20, 32'h3, 32'h28);
        put_desc(32'h28, 32'h3, 32'h30);
        put_desc(32'h30, 32'h6, 32'h0);
        d0 = done_cnt;
        reg_write(2'd0, 32'h20);
        expect_desc(32'h20); expect_desc(32'h28);
        reg_write(2'd1, 32'd2);
        idle_cycles(70);
        check_drained("R1");
        check_reg(2'd1, 32'd0, "R1", "count exhausted");
        check_reg(2'd0, 32'h30, "R5", "next addr holds continuation");
        check(done_cnt == d0, "R10", "no pulse without irq bit", done_cnt, d0);
        expect_desc(32'h30);
        reg_write(2'd1, 32'd1);
        idle_cycles(40);
        check_drained("R6");
        check(done_cnt == d0 + 1, "R6", "appended command ran", done_cnt, d0 + 1);

        // Unchained command with surplus count parks
        mem_lat = 1;
        put_desc(32'h38, 32'h6, 32'h0);
        f0 = fetch_cnt;
        reg_write(2'd0, 32'h38);
        expect_desc(32'h38);
        reg_write(2'd1, 32'd2);
        idle_cycles(60);
        check(fetch_cnt == f0 + 2, "R5", "single descriptor fetched", fetch_cnt, f0 + 2);
        check_reg(2'd1, 32'd1, "R5", "surplus count kept while parked");
        reg_write(2'd3, 32'd1);
        check_reg(2'd1, 32'd0, "R9", "reset clears parked count");

        // Semaphore write on the decrementing completion edge
        put_desc(32'h48, 32'h7, 32'h50);
        put_desc(32'h50, 32'h6, 32'h0);
        d0 = done_cnt;
        reg_write(2'd0, 32'h48);
        expect_desc(32'h48); expect_desc(32'h50);
        reg_write(2'd1, 32'd1);
        for (int k = 0; k < 60 && !cmd_done; k++) @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 32'd1;
        @(negedge clk);
        reg_we = 1'b0;
        check_reg(2'd1, 32'd1, "R7", "add and decrement same edge");
        idle_cycles(50);
        check_drained("R7");
        check_reg(2'd1, 32'd0, "R7", "second command consumed count");
        check(done_cnt == d0 + 2, "R7", "both commands completed", done_cnt, d0 + 2);

        // Gate set between the two descriptor reads
        mem_lat = 3;
        put_desc(32'h58, 32'h6, 32'h0);
        d0 = done_cnt;
        reg_write(2'd0, 32'h58);
        expect_desc(32'h58);
        reg_write(2'd1, 32'd1);
        for (int k = 0; k < 60 && !(mem_req && mem_addr == 32'h5C); k++) @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'd1;
        @(negedge clk);
        reg_we = 1'b0;
        idle_cycles(30);
        check_drained("R8");
        check(done_cnt == d0, "R8", "aborted command gives no pulse", done_cnt, d0);
        check_reg(2'd1, 32'd1, "R8", "abort leaves count");
        reg_write(2'd3, 32'd1);
        check_reg(2'd1, 32'd0, "R9", "reset after abort");
        f0 = fetch_cnt;
        reg_write(2'd2, 32'd0);
        idle_cycles(20);
        check(fetch_cnt == f0, "R1", "zero count issues no fetch", fetch_cnt, f0);

        // Channel reset during a completion of a looping chain
        mem_lat = 1;
        put_desc(32'h60, 32'h7, 32'h68);
        put_desc(32'h68, 32'h7, 32'h60);
        d0 = done_cnt;
        reg_write(2'd0, 32'h60);
        expect_desc(32'h60);
        reg_write(2'd1, 32'd5);
        for (int k = 0; k < 60 && !cmd_done; k++) @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 32'd1;
        @(negedge clk);
        reg_we = 1'b0;
        idle_cycles(30);
        check_drained("R9");
        check_reg(2'd1, 32'd0, "R9", "reset while running");
        check(done_cnt == d0 + 1, "R9", "no work after reset", done_cnt, d0 + 1);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule